// File: doc/BRIEF.md
# Expansion Autoconfiguration Responder

This block is the plug-and-play configuration window of a memory expansion card on a 16-bit bus. After reset, while the card is still unconfigured, it answers reads in its configuration space with identification nibbles. These nibbles give the board type, a memory size code and a manufacturer number. Each nibble appears on data lines 15:12, and all lower lines read as ones.

System software configures the card in one of two ways. It can write the card's base address, which maps the RAM at that address. It can instead send a shut-up write, which hides the card. Either write retires the window until the next reset. After that the block never claims the bus again. The configured flag and the base address it reports stay fixed.

RAM storage and the system address decoder are outside this block. The decoder qualifies `valid_i` for the configuration space and passes the low address byte. The size strap `size_sel_i` is held static between resets.

Top module: `autoconf_responder`

## Requirements
- R1: While reset is asserted and right after it, `claim_o` is 0 whenever `valid_i` is 0, `rdata_o` is 0, `configured_o` is 0 and `base_o` is 0.
- R2: The register index is `addr_i[7:1]`. `addr_i[0]` has no effect on reads or writes, so byte addresses 2k and 2k+1 behave the same.
- R3: A claimed read drives the 4-bit register value on `rdata_o[15:12]` and ones on `rdata_o[11:0]`.
- R4: Byte address 0x00 reads the value 0xE. This encodes the board type together with the flag that adds the memory to the free pool.
- R5: Byte address 0x02 reads the size code. `size_sel_i` 1 (1 MB) gives 5, 2 (2 MB) gives 6, 3 (4 MB) gives 7, and 4 (8 MB) gives 0.
- R6: Byte addresses 0x10 and 0x12 read 0xA. Byte addresses 0x14 and 0x16 read 0xB. These are the manufacturer nibbles.
- R7: Every other byte address reads 0xF.
- R8: A write to byte address 0x48 does three things. It loads `base_o` (address bits 23:16) from `wdata_i`. It sets `configured_o`. It hides the window from the next cycle.
- R9: A write to byte addresses 0x4C to 0x4F hides the window from the next cycle. `configured_o` and `base_o` are left unchanged.
- R10: When `size_sel_i` is 0 or greater than 4, no RAM is fitted. In that case `claim_o` is never asserted and writes change nothing.
- R11: While the window is visible and the RAM is fitted, `claim_o` equals `valid_i`. While the window is hidden, `claim_o` is 0 and `rdata_o` is 0. `rdata_o` is also 0 for any unclaimed access or write.
- R12: Once `configured_o` is set, it and `base_o` stay unchanged until reset. This holds even across further writes to 0x48.
- R13: A write to any register other than 0x48 and 0x4C to 0x4F has no effect: the window stays visible, and `configured_o` and `base_o` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Low byte of the bus address |
| rnw_i | input | 1 | 1 = read, 0 = write |
| valid_i | input | 1 | Access strobe, qualified for the configuration space |
| wdata_i | input | 8 | High byte of the write data |
| size_sel_i | input | 3 | Fitted RAM size: 0 none, 1 = 1 MB, 2 = 2 MB, 3 = 4 MB, 4 = 8 MB |
| rdata_o | output | 16 | Read data |
| claim_o | output | 1 | The block responds to the current access |
| configured_o | output | 1 | A base address has been accepted |
| base_o | output | 8 | RAM base address bits 23:16 |

## Verification
The assertions check the following on every cycle:
- the read-data format, with ones in the low twelve bits;
- silence when no RAM is fitted, and zero data whenever the block is not claiming;
- retirement of the window after a base-address or shut-up write;
- the base value loaded by a base-address write;
- the fixed configured state afterwards.

Only the bench's scenarios can show the rest:
- the actual nibble each register returns and the size-code mapping;
- that address bit 0 and writes to unrelated registers change nothing;
- that only reset restores the window.

// File: rtl/ac_pkg.sv
package ac_pkg;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = ADDR_W - 1;
  localparam int DATA_W = 16;
  localparam int NIB_W  = 4;
  localparam int BASE_W = 8;
  localparam int SIZE_W = 3;
  localparam int LOW_W  = DATA_W - NIB_W;

  typedef enum logic [SIZE_W-1:0] {
    SZ_NONE = 3'd0,
    SZ_1M   = 3'd1,
    SZ_2M   = 3'd2,
    SZ_4M   = 3'd3,
    SZ_8M   = 3'd4
  } size_e;

  // word indices (byte address >> 1)
  localparam logic [IDX_W-1:0] IDX_TYPE_HI = 7'h00;
  localparam logic [IDX_W-1:0] IDX_TYPE_LO = 7'h01;
  localparam logic [IDX_W-1:0] IDX_MFG_H0  = 7'h08;
  localparam logic [IDX_W-1:0] IDX_MFG_H1  = 7'h09;
  localparam logic [IDX_W-1:0] IDX_MFG_L0  = 7'h0A;
  localparam logic [IDX_W-1:0] IDX_MFG_L1  = 7'h0B;
  localparam logic [IDX_W-1:0] IDX_BASE    = 7'h24;
  localparam logic [IDX_W-1:0] IDX_SHUT0   = 7'h26;
  localparam logic [IDX_W-1:0] IDX_SHUT1   = 7'h27;

  localparam logic [NIB_W-1:0] NIB_TYPE  = 4'hE;
  localparam logic [NIB_W-1:0] NIB_MFG_H = 4'hA;
  localparam logic [NIB_W-1:0] NIB_MFG_L = 4'hB;
  localparam logic [NIB_W-1:0] NIB_IDLE  = 4'hF;

  function automatic logic size_fitted(logic [SIZE_W-1:0] s);
    return (s >= SZ_1M) && (s <= SZ_8M);
  endfunction

  function automatic logic [NIB_W-1:0] size_code(logic [SIZE_W-1:0] s);
    case (s)
      SZ_1M:   return 4'h5;
      SZ_2M:   return 4'h6;
      SZ_4M:   return 4'h7;
      SZ_8M:   return 4'h0;
      default: return NIB_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/ac_id_rom.sv
module ac_id_rom
  import ac_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [NIB_W-1:0]  nib_o
);
  always_comb begin
    unique case (idx_i)
      IDX_TYPE_HI:            nib_o = NIB_TYPE;
      IDX_TYPE_LO:            nib_o = size_code(size_i);
      IDX_MFG_H0, IDX_MFG_H1: nib_o = NIB_MFG_H;
      IDX_MFG_L0, IDX_MFG_L1: nib_o = NIB_MFG_L;
      default:                nib_o = NIB_IDLE;
    endcase
  end
endmodule

// File: rtl/ac_cfg_state.sv
module ac_cfg_state
  import ac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BASE_W-1:0] wdata_i,
  output logic              open_o,
  output logic              configured_o,
  output logic [BASE_W-1:0] base_o
);
  logic hit_base, hit_shut;

  assign hit_base = wr_i && (idx_i == IDX_BASE);
  assign hit_shut = wr_i && ((idx_i == IDX_SHUT0) || (idx_i == IDX_SHUT1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o       <= 1'b1;
      configured_o <= 1'b0;
      base_o       <= '0;
    end else if (open_o) begin
      if (hit_base) begin
        base_o       <= wdata_i;
        configured_o <= 1'b1;
        open_o       <= 1'b0;
      end else if (hit_shut) begin
        open_o       <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/autoconf_responder.sv
module autoconf_responder
  import ac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rnw_i,
  input  logic              valid_i,
  input  logic [BASE_W-1:0] wdata_i,
  input  logic [SIZE_W-1:0] size_sel_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              claim_o,
  output logic              configured_o,
  output logic [BASE_W-1:0] base_o
);
  logic [IDX_W-1:0] idx;
  logic [NIB_W-1:0] nib;
  logic             open_q, live;
  logic             unused_a0;

  assign idx       = addr_i[ADDR_W-1:1];
  assign unused_a0 = addr_i[0];
  assign live      = open_q && size_fitted(size_sel_i);
  assign claim_o   = valid_i && live;
  assign rdata_o   = (claim_o && rnw_i) ? {nib, {LOW_W{1'b1}}} : '0;

  ac_id_rom u_rom (
    .idx_i  (idx),
    .size_i (size_sel_i),
    .nib_o  (nib)
  );

  ac_cfg_state u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (claim_o && !rnw_i),
    .idx_i        (idx),
    .wdata_i      (wdata_i),
    .open_o       (open_q),
    .configured_o (configured_o),
    .base_o       (base_o)
  );
endmodule

// File: rtl/ac_chk.sv
module ac_chk
  import ac_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rnw_i,
  input logic              valid_i,
  input logic [BASE_W-1:0] wdata_i,
  input logic [SIZE_W-1:0] size_sel_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              claim_o,
  input logic              configured_o,
  input logic [BASE_W-1:0] base_o
);
  logic wr_cl;
  assign wr_cl = claim_o && !rnw_i;

  a_r3_low_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_o && rnw_i) |-> (rdata_o[LOW_W-1:0] == {LOW_W{1'b1}}));

  a_r10_no_ram_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !size_fitted(size_sel_i) |-> !claim_o);

  a_r11_quiet_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(claim_o && rnw_i) |-> (rdata_o == '0));

  a_r11_claim_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> valid_i);

  a_r8_base_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cl && addr_i[ADDR_W-1:1] == IDX_BASE) |=>
      (configured_o && base_o == $past(wdata_i) && !claim_o));

  a_r9_shut_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cl && (addr_i[ADDR_W-1:1] == IDX_SHUT0 || addr_i[ADDR_W-1:1] == IDX_SHUT1)) |=>
      (!claim_o && $stable(configured_o) && $stable(base_o)));

  a_r12_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    configured_o |=> (configured_o && $stable(base_o) && !claim_o));
endmodule

bind autoconf_responder ac_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .rnw_i        (rnw_i),
  .valid_i      (valid_i),
  .wdata_i      (wdata_i),
  .size_sel_i   (size_sel_i),
  .rdata_o      (rdata_o),
  .claim_o      (claim_o),
  .configured_o (configured_o),
  .base_o       (base_o)
);

// File: tb/sim_autoconf_responder.sv
module sim_autoconf_responder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        rnw_i = 1'b1;
  logic        valid_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [2:0]  size_sel_i = 3'd1;
  logic [15:0] rdata_o;
  logic        claim_o, configured_o;
  logic [7:0]  base_o;

  int errors = 0;
  int checks = 0;
  // reference model state
  int m_open = 1, m_cfg = 0, m_base = 0;

  always #5 clk_i = ~clk_i;

  autoconf_responder u0 (.*);

  function automatic int fitted(int s);
    return (s >= 1 && s <= 4) ? 1 : 0;
  endfunction

  function automatic int nib_for(int a, int s);
    int w;
    w = a & 8'hFE;
    if (w == 8'h00) return 14;
    if (w == 8'h02) begin
      if (s == 1) return 5;
      if (s == 2) return 6;
      if (s == 3) return 7;
      if (s == 4) return 0;
      return 15;
    end
    if (w == 8'h10 || w == 8'h12) return 10;
    if (w == 8'h14 || w == 8'h16) return 11;
    return 15;
  endfunction

  task automatic compare(string tag);
    int e_claim, e_rd;
    e_claim = (valid_i && m_open && fitted(int'(size_sel_i))) ? 1 : 0;
    e_rd = (e_claim && rnw_i) ? ((nib_for(int'(addr_i), int'(size_sel_i)) << 12) | 16'h0FFF) : 0;
    checks++;
    if (int'(claim_o) != e_claim || int'(rdata_o) != e_rd ||
        int'(configured_o) != m_cfg || int'(base_o) != m_base) begin
      errors++;
      $display("FAIL %s: claim=%0d rdata=%h cfg=%0d base=%h expected claim=%0d rdata=%h cfg=%0d base=%h",
               tag, claim_o, rdata_o, configured_o, base_o, e_claim, e_rd[15:0], m_cfg, m_base[7:0]);
    end
  endtask

  task automatic step(string tag, int a, int rnw, int v, int wd);
    int w;
    @(negedge clk_i);
    addr_i = 8'(a); rnw_i = 1'(rnw); valid_i = 1'(v); wdata_i = 8'(wd);
    #1 compare(tag);
    @(posedge clk_i);
    if (rst_ni && v && !rnw && m_open && fitted(int'(size_sel_i))) begin
      w = a & 8'hFE;
      if (w == 8'h48) begin m_base = wd & 8'hFF; m_cfg = 1; m_open = 0; end
      else if (w == 8'h4C || w == 8'h4E) m_open = 0;
    end
  endtask

  task automatic do_reset(int sz);
    @(negedge clk_i);
    rst_ni = 1'b0; size_sel_i = 3'(sz); valid_i = 1'b0; rnw_i = 1'b1;
    m_open = 1; m_cfg = 0; m_base = 0;
    #1 compare("R1_in_reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1 compare("R1_after_reset");
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(1);
    step("R11_idle", 8'h00, 1, 0, 0);
    step("R4_type", 8'h00, 1, 1, 0);
    step("R2_type_odd", 8'h01, 1, 1, 0);
    step("R5_size_1m", 8'h02, 1, 1, 0);
    step("R6_mfg_hi", 8'h10, 1, 1, 0);
    step("R6_mfg_hi2", 8'h13, 1, 1, 0);
    step("R6_mfg_lo", 8'h14, 1, 1, 0);
    step("R6_mfg_lo2", 8'h17, 1, 1, 0);
    step("R7_other", 8'h20, 1, 1, 0);
    step("R7_top", 8'hFE, 1, 1, 0);
    step("R3_format", 8'h04, 1, 1, 0);
    step("R13_write_other", 8'h40, 0, 1, 8'h55);
    step("R13_write_4a", 8'h4A, 0, 1, 8'h66);
    step("R13_still_open", 8'h00, 1, 1, 0);
    step("R8_base_write", 8'h49, 0, 1, 8'h20);
    step("R8_hidden", 8'h00, 1, 1, 0);
    step("R12_rewrite", 8'h48, 0, 1, 8'h30);
    step("R12_stable", 8'h02, 1, 1, 0);
    step("R11_shut_ignored", 8'h4C, 0, 1, 8'h00);
    step("R12_stable2", 8'h10, 1, 1, 0);

    do_reset(3);
    step("R5_size_4m", 8'h02, 1, 1, 0);
    step("R9_shut", 8'h4D, 0, 1, 8'hC0);
    step("R9_hidden", 8'h00, 1, 1, 0);
    step("R11_base_ignored", 8'h48, 0, 1, 8'h40);
    step("R9_not_cfg", 8'h02, 1, 1, 0);

    do_reset(2);
    step("R5_size_2m", 8'h03, 1, 1, 0);
    step("R9_shut_4e", 8'h4E, 0, 1, 8'h11);
    step("R9_hidden2", 8'h02, 1, 1, 0);

    do_reset(4);
    step("R5_size_8m", 8'h02, 1, 1, 0);
    step("R8_base_ff", 8'h48, 0, 1, 8'hFF);
    step("R12_after", 8'h14, 1, 1, 0);

    do_reset(0);
    step("R10_read", 8'h00, 1, 1, 0);
    step("R10_write", 8'h48, 0, 1, 8'h20);
    step("R10_after", 8'h02, 1, 1, 0);

    do_reset(5);
    step("R10_bad_size", 8'h00, 1, 1, 0);
    step("R10_bad_write", 8'h48, 0, 1, 8'h77);
    step("R10_bad_after", 8'h00, 1, 1, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule